// File: doc/BRIEF.md
# Vector Length Control Register Unit

This block owns the vector length (VL) state of a scalar core that issues vector operations. It answers two control-register addresses that share one physical VL register. Accesses to the primary address apply set-length semantics: the requested length is clamped into the range one to a configured maximum, stored, and the newly stored value is handed back to the destination register. Accesses to the alias address behave like any ordinary control register: they return the old VL and store the new one. The alias exists so that a context save and restore can capture the old length with a single swap.

A control-register access arrives as a one-cycle request. It carries:

- a valid flag;
- a 12-bit address;
- an operation: write, set bits or clear bits;
- a source operand, taken either from a register value or from a 5-bit immediate;
- the destination register index.

One clock edge later the block presents the writeback enable, the destination index and the writeback data. At the same time it presents the updated VL for the element sequencer. The maximum length must lie between the register-file length and XLEN, so that one predicate bit per element fits in a single register.

Top module: `vl_csr_unit`

## Requirements
- R1: After reset, VL reads 1 and the writeback enable is low.
- R2: The operation code is 2 bits: 1 = write, 2 = set bits, 3 = clear bits. A write to the primary address (`ADDR_VL`) stores MIN(operand, MAXVL) into VL. The same value is returned as writeback data. Both appear on the cycle after the request.
- R3: Any computed new length of zero is stored and returned as 1.
- R4: When the destination index is 0, the writeback enable stays low. VL is still updated.
- R5: An access to the alias address (`ADDR_VL_REAL`) returns the VL held before the access and stores the clamped new value.
- R6: Set and clear operations on either address compute `VL | operand` or `VL & ~operand` from the current VL. The result is then clamped into 1..MAXVL.
- R7: A set or clear whose operand is zero leaves VL unchanged. It returns the current VL on either address.
- R8: When the immediate form is selected, the operand is the 5-bit immediate zero-extended to XLEN, and the register operand is ignored.
- R9: A request is ignored when its address is neither VL address, or when its valid flag is low. An ignored request gives no writeback and leaves VL unchanged.
- R10: VL always lies in 1..MAXVL. Operands above MAXVL in any bit position clamp to MAXVL. Writeback data is zero above the VL width.
- R11: Operation code 0 is reserved. It causes no writeback and no change of VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csrValid | input | 1 | Access request strobe |
| csrAddr | input | 12 | Control-register address |
| csrOp | input | 2 | 0 reserved, 1 write, 2 set bits, 3 clear bits |
| csrUseImm | input | 1 | Select the immediate as operand |
| csrSrc | input | XLEN | Register operand |
| csrImm | input | 5 | Immediate operand |
| csrRdIdx | input | 5 | Destination register index |
| wbEn | output | 1 | Destination writeback enable |
| wbIdx | output | 5 | Destination register index for writeback |
| wbData | output | XLEN | Writeback value |
| vlCurrent | output | VLW | Current vector length |

## Verification
The assertions assume that the request fields are stable and known around each rising edge while `csrValid` is high. They also assume that reset is held for at least one edge before any request. The alias and primary checks further assume that the two address parameters differ. The bench drives every request on the falling edge, holds it for a full period, and keeps the default addresses distinct. This keeps every input pattern inside those assumptions.

// File: rtl/vl_csr_pkg.sv
package vl_csr_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csrOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   hit;      // accepted access to one of the two VL addresses
    logic   primary;  // access targets the set-length address
    logic   doWrite;  // VL register takes a new value
    logic   rdWrite;  // destination register is written
    csrOp_e op;
  } vlStrobe_t;

endpackage

// File: rtl/vl_clamp.sv
module vl_clamp #(
  parameter int XLEN  = 32,
  parameter int MAXVL = 32,
  parameter int VLW   = $clog2(MAXVL) + 1
) (
  input  logic [XLEN-1:0] rawLen,
  output logic [VLW-1:0]  clampedLen
);
  localparam logic [XLEN-1:0] MaxWide = XLEN'(MAXVL);
  localparam logic [VLW-1:0]  MaxNarrow = VLW'(MAXVL);

  always_comb begin
    if (rawLen == '0) begin
      clampedLen = VLW'(1);
    end else if (rawLen > MaxWide) begin
      clampedLen = MaxNarrow;
    end else begin
      clampedLen = rawLen[VLW-1:0];
    end
  end
endmodule

// File: rtl/vl_csr_ctrl.sv
module vl_csr_ctrl
  import vl_csr_pkg::*;
#(
  parameter logic [11:0] ADDR_VL      = 12'h7c0,
  parameter logic [11:0] ADDR_VL_REAL = 12'h7c1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csrValid,
  input  logic [11:0] csrAddr,
  input  logic [1:0]  csrOp,
  input  logic [4:0]  csrRdIdx,
  input  logic        operandZero,
  output vlStrobe_t   strobes
);
  logic   hitPrimary;
  logic   hitAlias;
  logic   accept;
  csrOp_e opDec;

  always_comb begin
    opDec      = csrOp_e'(csrOp);
    hitPrimary = (csrAddr == ADDR_VL);
    hitAlias   = (csrAddr == ADDR_VL_REAL);
    accept     = csrValid && (hitPrimary || hitAlias) && (opDec != OP_NONE);

    strobes.hit     = accept;
    strobes.primary = accept && hitPrimary;
    strobes.op      = opDec;
    // set/clear with a zero operand is a pure read
    strobes.doWrite = accept && ((opDec == OP_WRITE) || !operandZero);
    strobes.rdWrite = accept && (csrRdIdx != 5'd0);
  end

  // R9 / R11: nothing reaches the datapath without a legal access
  assert_reject_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (!csrValid || (csrOp == 2'd0)) |-> (!strobes.doWrite && !strobes.rdWrite));

endmodule

// File: rtl/vl_csr_dp.sv
module vl_csr_dp
  import vl_csr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int MAXVL = 32,
  parameter int VLW   = $clog2(MAXVL) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  vlStrobe_t       strobes,
  input  logic            csrUseImm,
  input  logic [XLEN-1:0] csrSrc,
  input  logic [4:0]      csrImm,
  input  logic [4:0]      csrRdIdx,
  output logic            operandZero,
  output logic            wbEn,
  output logic [4:0]      wbIdx,
  output logic [XLEN-1:0] wbData,
  output logic [VLW-1:0]  vlCurrent
);
  logic [VLW-1:0]  vlQ;
  logic [XLEN-1:0] vlWide;
  logic [XLEN-1:0] operand;
  logic [XLEN-1:0] rawLen;
  logic [VLW-1:0]  newLen;
  logic [XLEN-1:0] wbNext;

  always_comb begin
    operand     = csrUseImm ? XLEN'(csrImm) : csrSrc;
    operandZero = (operand == '0);
    vlWide      = XLEN'(vlQ);
    unique case (strobes.op)
      OP_SET:   rawLen = vlWide | operand;
      OP_CLEAR: rawLen = vlWide & ~operand;
      default:  rawLen = operand;
    endcase
  end

  vl_clamp #(.XLEN(XLEN), .MAXVL(MAXVL), .VLW(VLW)) i_clamp (
    .rawLen    (rawLen),
    .clampedLen(newLen)
  );

  // primary address hands back the stored new length, alias the old one
  always_comb begin
    if (strobes.primary && strobes.doWrite) wbNext = XLEN'(newLen);
    else                                    wbNext = vlWide;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vlQ    <= VLW'(1);
      wbEn   <= 1'b0;
      wbIdx  <= 5'd0;
      wbData <= '0;
    end else begin
      if (strobes.doWrite) vlQ <= newLen;
      wbEn <= strobes.rdWrite;
      if (strobes.hit) begin
        wbIdx  <= csrRdIdx;
        wbData <= wbNext;
      end
    end
  end

  assign vlCurrent = vlQ;

  assert_vl_range_R10 : assert property (@(posedge clk) disable iff (!rstN)
    (vlQ >= VLW'(1)) && (vlQ <= VLW'(MAXVL)));

  assert_no_x0_wb_R4 : assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (wbIdx != 5'd0));

  assert_alias_old_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdWrite && !strobes.primary) |=> (wbData == XLEN'($past(vlQ))));

  assert_primary_new_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdWrite && strobes.primary) |=> (wbData == XLEN'(vlQ)));

  assert_hold_R9 : assert property (@(posedge clk) disable iff (!rstN)
    !strobes.hit |=> $stable(vlQ));

endmodule

// File: rtl/vl_csr_unit.sv
module vl_csr_unit
  import vl_csr_pkg::*;
#(
  parameter int          XLEN         = 32,
  parameter int          MAXVL        = 32,
  parameter logic [11:0] ADDR_VL      = 12'h7c0,
  parameter logic [11:0] ADDR_VL_REAL = 12'h7c1,
  localparam int         VLW          = $clog2(MAXVL) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csrValid,
  input  logic [11:0]     csrAddr,
  input  logic [1:0]      csrOp,
  input  logic            csrUseImm,
  input  logic [XLEN-1:0] csrSrc,
  input  logic [4:0]      csrImm,
  input  logic [4:0]      csrRdIdx,
  output logic            wbEn,
  output logic [4:0]      wbIdx,
  output logic [XLEN-1:0] wbData,
  output logic [VLW-1:0]  vlCurrent
);
  vlStrobe_t strobes;
  logic      operandZero;

  vl_csr_ctrl #(.ADDR_VL(ADDR_VL), .ADDR_VL_REAL(ADDR_VL_REAL)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csrValid   (csrValid),
    .csrAddr    (csrAddr),
    .csrOp      (csrOp),
    .csrRdIdx   (csrRdIdx),
    .operandZero(operandZero),
    .strobes    (strobes)
  );

  vl_csr_dp #(.XLEN(XLEN), .MAXVL(MAXVL), .VLW(VLW)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .csrUseImm  (csrUseImm),
    .csrSrc     (csrSrc),
    .csrImm     (csrImm),
    .csrRdIdx   (csrRdIdx),
    .operandZero(operandZero),
    .wbEn       (wbEn),
    .wbIdx      (wbIdx),
    .wbData     (wbData),
    .vlCurrent  (vlCurrent)
  );
endmodule

// File: tb/test_vl_csr_unit.sv
module test_vl_csr_unit;
  localparam int XLEN = 32;
  localparam int MAXVL = 32;
  localparam int VLW = $clog2(MAXVL) + 1;
  localparam logic [11:0] A_VL = 12'h7c0;
  localparam logic [11:0] A_REAL = 12'h7c1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csrValid = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [1:0] csrOp = '0;
  logic csrUseImm = 1'b0;
  logic [XLEN-1:0] csrSrc = '0;
  logic [4:0] csrImm = '0;
  logic [4:0] csrRdIdx = '0;
  logic wbEn;
  logic [4:0] wbIdx;
  logic [XLEN-1:0] wbData;
  logic [VLW-1:0] vlCurrent;

  int tests = 0;
  int fails = 0;
  int modelVl = 1;
  bit finished = 1'b0;

  typedef struct {
    string req;
    bit en;
    int idx;
    longint data;
    int vl;
  } expect_t;
  expect_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  vl_csr_unit i_vl_csr_unit (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrAddr(csrAddr),
    .csrOp(csrOp), .csrUseImm(csrUseImm), .csrSrc(csrSrc), .csrImm(csrImm),
    .csrRdIdx(csrRdIdx), .wbEn(wbEn), .wbIdx(wbIdx), .wbData(wbData),
    .vlCurrent(vlCurrent)
  );

  function automatic int clampLen(longint raw);
    if (raw == 0) return 1;
    if (raw > MAXVL) return MAXVL;
    return int'(raw);
  endfunction

  task automatic check(string req, longint act, longint exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: apply one request on the falling edge and push its prediction
  task automatic drive(string req, bit valid, logic [11:0] addr, int op,
                       bit useImm, logic [XLEN-1:0] src, logic [4:0] imm, int rd);
    expect_t e;
    longint operand;
    longint raw;
    bit legal;
    bit writes;
    int oldVl;
    @(negedge clk);
    csrValid = valid; csrAddr = addr; csrOp = 2'(op); csrUseImm = useImm;
    csrSrc = src; csrImm = imm; csrRdIdx = 5'(rd);
    operand = useImm ? longint'(imm) : longint'(src);
    legal = valid && (addr == A_VL || addr == A_REAL) && op != 0;
    oldVl = modelVl;
    case (op)
      2: raw = longint'(oldVl) | operand;
      3: raw = longint'(oldVl) & ~operand;
      default: raw = operand;
    endcase
    writes = legal && (op == 1 || operand != 0);
    if (writes) modelVl = clampLen(raw);
    e.req = req;
    e.en = legal && rd != 0;
    e.idx = rd;
    e.data = (addr == A_VL && writes) ? longint'(modelVl) : longint'(oldVl);
    e.vl = modelVl;
    sb.push_back(e);
  endtask

  // monitor: compare mid-cycle after the edge that took the request
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      expect_t e;
      e = sb.pop_front();
      check(e.req, longint'(wbEn), longint'(e.en), "wbEn");
      check(e.req, longint'(vlCurrent), longint'(e.vl), "vl");
      if (e.en) begin
        check(e.req, longint'(wbIdx), longint'(e.idx), "wbIdx");
        check(e.req, longint'(wbData), e.data, "wbData");
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", longint'(vlCurrent), 1, "reset vl");
    check("R1", longint'(wbEn), 0, "reset wbEn");

    drive("R2", 1, A_VL, 1, 0, 32'd10, 5'd0, 5);
    drive("R2", 1, A_VL, 1, 0, 32'd100, 5'd0, 3);
    drive("R3", 1, A_VL, 1, 0, 32'd0, 5'd0, 1);
    drive("R4", 1, A_VL, 1, 0, 32'd7, 5'd0, 0);
    drive("R5", 1, A_REAL, 1, 0, 32'd20, 5'd0, 4);
    drive("R5", 1, A_REAL, 1, 0, 32'd50, 5'd0, 4);
    drive("R8", 1, A_VL, 1, 1, 32'd99, 5'd5, 2);
    drive("R6", 1, A_VL, 2, 0, 32'd8, 5'd0, 2);
    drive("R6", 1, A_VL, 3, 0, 32'd1, 5'd0, 2);
    drive("R6", 1, A_VL, 3, 0, 32'hC, 5'd0, 7);
    drive("R6", 1, A_REAL, 2, 0, 32'h40, 5'd0, 8);
    drive("R7", 1, A_VL, 2, 0, 32'd0, 5'd0, 6);
    drive("R7", 1, A_REAL, 3, 1, 32'hFF, 5'd0, 9);
    drive("R9", 1, 12'h300, 1, 0, 32'd3, 5'd0, 5);
    drive("R11", 1, A_VL, 0, 0, 32'd3, 5'd0, 5);
    drive("R9", 0, A_VL, 1, 0, 32'd3, 5'd0, 5);
    drive("R10", 1, A_VL, 1, 0, 32'hFFFF_FFFF, 5'd0, 11);
    drive("R10", 1, A_VL, 1, 0, 32'd4, 5'd0, 12);
    drive("R10", 1, A_REAL, 1, 0, 32'h8000_0003, 5'd0, 13);
    drive("R4", 1, A_REAL, 1, 1, 32'd0, 5'd9, 0);
    drive("R2", 1, A_VL, 1, 0, 32'd32, 5'd0, 31);

    @(negedge clk);
    csrValid = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule